// File: doc/BRIEF.md
# Programmable SDRAM Command Timing Sequencer

This block turns one CPU-initiated memory access into the SDRAM command sequence it needs. A page hit needs only a column read or write. An access to a bank with no open row needs a row activate and then the column command. A page miss needs a precharge, then an activate, then the column command. The requester supplies the address, the direction and the page status. The block drives chip select, the three command strobes and the multiplexed address. For reads it also gives a data-valid strobe. It signals completion when the access ends.

Three separate configuration bits set three delays, each to two or three clocks: the row-to-column delay, the precharge-to-activate time and the CAS latency. Any mix of these settings works. A leadoff bit picks whether a read's first chip select falls in clock 3 or clock 4, counting the cycle in which the request is accepted as clock 1. In the fast setting the command and address lines are already driven in clock 2. The configuration is captured when a request is accepted, so changing it during an access has no effect. A new request may be accepted in the same cycle in which the previous access completes.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While reset is held and after it is released, cs_n, ras_n, cas_n and we_n are high, rd_valid and done are low, and req_ready is high.
- R2: A page hit (req_state 2'b00) issues only one column command. A read is encoded {ras_n,cas_n,we_n}=3'b101 and a write is 3'b100. The command carries the column, zero-extended, on ma (so ma[10] is low) and the request bank on ba.
- R3: A row-empty access (req_state 2'b01) issues an activate (3'b011) with the row on ma and the bank on ba, followed by the column command.
- R4: A page miss (req_state 2'b10) issues a precharge (3'b010) with ma all zero and the bank on ba, then an activate, then the column command.
- R5: The column command follows the activate by 3 clocks when cfg_rcd3 is 1 and by 2 clocks when it is 0.
- R6: The activate follows the precharge by 3 clocks when cfg_rp3 is 1 and by 2 clocks when it is 0. No two chip-select assertions fall in adjacent cycles.
- R7: For a read, rd_valid is high for one cycle, exactly 3 clocks after the column read cycle when cfg_cl3 is 1 and exactly 2 clocks after it when cfg_cl3 is 0.
- R8: The first chip select of a read falls in clock 3 when cfg_lead_fast is 1 and in clock 4 when it is 0. For a write it always falls in clock 3. Clock 1 is the cycle in which req_valid and req_ready are both high.
- R9: For a read with cfg_lead_fast set, clock 2 carries the first command's strobes and address with cs_n high. In every other cycle in which cs_n is high, ras_n, cas_n and we_n are all high.
- R10: done pulses for one cycle. For a read it pulses together with rd_valid; for a write it pulses the clock after the column command. req_ready is high in the done cycle, so a request presented in that cycle starts a new access.
- R11: The configuration bits and the request fields are captured at acceptance. Changing them during an access does not change its commands or its timing.
- R12: A request presented while req_ready is low is ignored. No extra command follows the current access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_state | input | 2 | Page status: 00 hit, 01 row empty, 10 miss |
| req_bank | input | BANK_W | Bank address |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| cfg_cl3 | input | 1 | CAS latency 3 (else 2) |
| cfg_rcd3 | input | 1 | Row-to-column delay 3 (else 2) |
| cfg_rp3 | input | 1 | Precharge time 3 (else 2) |
| cfg_lead_fast | input | 1 | Read leadoff chip select in clock 3 (else clock 4) |
| req_ready | output | 1 | Sequencer idle, request can be accepted |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address to the device |
| ma | output | MA_W | Multiplexed row or column address |
| rd_valid | output | 1 | Read data valid strobe |
| done | output | 1 | Access complete |

## Verification
The completion of one access and the acceptance of the next can fall in the same cycle. The bench provokes this by presenting each new request from the stimulus table in the exact cycle in which done (and, for reads, rd_valid) of the previous access is seen. The bench then requires that both the previous access's strobe timing and the new access's leadoff clock numbering hold exactly, with the new access's clock 1 taken as that done cycle. A separate run keeps a conflicting request and inverted configuration on the inputs throughout a busy access. It then requires unchanged commands and silence on the command lines afterwards.

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq #(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int BANK_W = 2,
  parameter int MA_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_state,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              cfg_cl3,
  input  logic              cfg_rcd3,
  input  logic              cfg_rp3,
  input  logic              cfg_lead_fast,
  output logic              req_ready,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] ba,
  output logic [MA_W-1:0]   ma,
  output logic              rd_valid,
  output logic              done
);
  localparam logic [2:0] CMD_NOP = 3'b111;
  localparam logic [1:0] PH_PRE = 2'd0, PH_ACT = 2'd1, PH_COL = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_TAIL} st_t;

  st_t              st;
  logic [1:0]       ph, wcnt, in_ph;
  logic [2:0]       cmd_q;
  logic             wr_q, cl3_q, rcd3_q, rp3_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;

  function automatic logic [2:0] cmd_of(input logic [1:0] p, input logic wr);
    case (p)
      PH_PRE:  cmd_of = 3'b010;
      PH_ACT:  cmd_of = 3'b011;
      default: cmd_of = wr ? 3'b100 : 3'b101;
    endcase
  endfunction

  function automatic logic [MA_W-1:0] ma_of(input logic [1:0] p,
      input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c);
    case (p)
      PH_PRE:  ma_of = '0;
      PH_ACT:  ma_of = MA_W'(r);
      default: ma_of = MA_W'(c);
    endcase
  endfunction

  assign in_ph = (req_state == 2'b00) ? PH_COL : (req_state == 2'b01) ? PH_ACT : PH_PRE;
  assign req_ready = (st == S_IDLE);
  assign {ras_n, cas_n, we_n} = cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= PH_PRE; wcnt <= '0;
      cs_n <= 1'b1; cmd_q <= CMD_NOP; ma <= '0; ba <= '0;
      rd_valid <= 1'b0; done <= 1'b0;
      wr_q <= 1'b0; cl3_q <= 1'b0; rcd3_q <= 1'b0; rp3_q <= 1'b0;
      row_q <= '0; col_q <= '0;
    end else begin
      cs_n <= 1'b1; cmd_q <= CMD_NOP; rd_valid <= 1'b0; done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          st <= S_WAIT; ph <= in_ph;
          wr_q <= req_write; cl3_q <= cfg_cl3; rcd3_q <= cfg_rcd3; rp3_q <= cfg_rp3;
          row_q <= req_row; col_q <= req_col; ba <= req_bank;
          wcnt <= (!req_write && !cfg_lead_fast) ? 2'd1 : 2'd0;
          if (!req_write && cfg_lead_fast) begin
            cmd_q <= cmd_of(in_ph, req_write);
            ma    <= ma_of(in_ph, req_row, req_col);
          end
        end
        S_WAIT: if (wcnt == 2'd0) begin
          cs_n  <= 1'b0;
          cmd_q <= cmd_of(ph, wr_q);
          ma    <= ma_of(ph, row_q, col_q);
          case (ph)
            PH_PRE:  begin ph <= PH_ACT; wcnt <= rp3_q ? 2'd2 : 2'd1; end
            PH_ACT:  begin ph <= PH_COL; wcnt <= rcd3_q ? 2'd2 : 2'd1; end
            default: begin st <= S_TAIL; wcnt <= wr_q ? 2'd0 : (cl3_q ? 2'd2 : 2'd1); end
          endcase
        end else wcnt <= wcnt - 2'd1;
        default: if (wcnt == 2'd0) begin
          done <= 1'b1; rd_valid <= !wr_q; st <= S_IDLE;
        end else wcnt <= wcnt - 2'd1;
      endcase
    end
  end

  logic rd_cmd;
  assign rd_cmd = !cs_n && (cmd_q == 3'b101);

  assert_rd_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (cl3_q ? $past(rd_cmd, 3) : $past(rd_cmd, 2)));
  assert_done_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (done && req_ready));
  assert_cs_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> cs_n);
  assert_nop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && (cmd_q != CMD_NOP)) |=> !cs_n);
  assert_predrive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid && !req_write && cfg_lead_fast) |=> (cs_n && (cmd_q != CMD_NOP)));
  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> ($stable(cl3_q) && $stable(rcd3_q) && $stable(rp3_q) && $stable(wr_q)));
endmodule

// File: tb/sdram_cmd_seq_tb.sv
`timescale 1ns/1ps
module sdram_cmd_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, cfg_cl3 = 0, cfg_rcd3 = 0, cfg_rp3 = 0, cfg_lead_fast = 0;
  logic [1:0] req_state = 0, req_bank = 0, ba;
  logic [11:0] req_row = 0, ma;
  logic [8:0] req_col = 0;
  logic req_ready, cs_n, ras_n, cas_n, we_n, rd_valid, done;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sdram_cmd_seq u_dut (.clk, .rst_n, .req_valid, .req_write, .req_state, .req_bank,
    .req_row, .req_col, .cfg_cl3, .cfg_rcd3, .cfg_rp3, .cfg_lead_fast, .req_ready,
    .cs_n, .ras_n, .cas_n, .we_n, .ba, .ma, .rd_valid, .done);

  // {write, state[1:0], cl3, rcd3, rp3, fast, expected done clock[4:0]}
  localparam int NV = 11;
  localparam logic [11:0] VEC [NV] = '{
    {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd5},
    {1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd7},
    {1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 5'd7},
    {1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 5'd10},
    {1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 5'd9},
    {1'b0, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 5'd12},
    {1'b0, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 5'd11},
    {1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd4},
    {1'b1, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 5'd10},
    {1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd6},
    {1'b0, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 5'd12}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_acc(input logic w, input logic [1:0] stt, input logic cl3, rcd3, rp3, fast,
      input int exp_done, input bit noise, input logic [1:0] bk, input logic [11:0] rw,
      input logic [8:0] cl);
    int c, ncs, p, nexp, done_c, rdv_c;
    int ecyc [3];
    logic [2:0] ecmd [3];
    logic [11:0] ema [3];
    bit bad_nop, rdy_done;
    nexp = 0;
    p = (!w && !fast) ? 4 : 3;
    if (stt == 2'd2) begin ecyc[nexp] = p; ecmd[nexp] = 3'b010; ema[nexp] = 12'h0; nexp++; p += rp3 ? 3 : 2; end
    if (stt != 2'd0) begin ecyc[nexp] = p; ecmd[nexp] = 3'b011; ema[nexp] = rw; nexp++; p += rcd3 ? 3 : 2; end
    ecyc[nexp] = p; ecmd[nexp] = w ? 3'b100 : 3'b101; ema[nexp] = {3'b000, cl}; nexp++;
    p += w ? 1 : (cl3 ? 3 : 2);
    chk(p == exp_done, "R8 table vs rule", exp_done, p);
    chk(req_ready == 1'b1, "R10 ready at clock 1", int'(req_ready), 1);
    req_valid = 1; req_write = w; req_state = stt; req_bank = bk; req_row = rw; req_col = cl;
    cfg_cl3 = cl3; cfg_rcd3 = rcd3; cfg_rp3 = rp3; cfg_lead_fast = fast;
    c = 1; ncs = 0; done_c = 0; rdv_c = 0; bad_nop = 0; rdy_done = 0;
    while (done_c == 0 && c < 40) begin
      @(negedge clk);
      c++;
      if (!cs_n) begin
        if (ncs < nexp) begin
          chk(c == ecyc[ncs], "R8/R5/R6 command clock", c, ecyc[ncs]);
          chk({ras_n, cas_n, we_n} == ecmd[ncs], "R2/R3/R4 command code", {ras_n, cas_n, we_n}, ecmd[ncs]);
          chk(ma == ema[ncs] && ba == bk, "R2/R3/R4 address", ma, ema[ncs]);
        end else chk(0, "R2 extra command", ncs + 1, nexp);
        ncs++;
      end else if ({ras_n, cas_n, we_n} != 3'b111) begin
        if (!(c == 2 && !w && fast && {ras_n, cas_n, we_n} == ecmd[0] && ma == ema[0])) bad_nop = 1;
      end
      if (c == 2)
        chk({ras_n, cas_n, we_n} == ((!w && fast) ? ecmd[0] : 3'b111) && cs_n,
            "R9 clock 2 lines", {cs_n, ras_n, cas_n, we_n}, {1'b1, (!w && fast) ? ecmd[0] : 3'b111});
      if (rd_valid) rdv_c = c;
      if (done) begin done_c = c; rdy_done = req_ready; end
      if (noise && c < exp_done) begin
        req_valid = 1; req_write = ~w; req_state = 2'd0; req_row = ~rw; req_col = ~cl;
        cfg_cl3 = ~cl3; cfg_rcd3 = ~rcd3; cfg_rp3 = ~rp3; cfg_lead_fast = ~fast;
      end else begin
        req_valid = 0; req_write = w;
        cfg_cl3 = cl3; cfg_rcd3 = rcd3; cfg_rp3 = rp3; cfg_lead_fast = fast;
      end
    end
    chk(ncs == nexp, "R2/R3/R4 command count", ncs, nexp);
    chk(done_c == exp_done, "R10 done clock", done_c, exp_done);
    chk(rdv_c == (w ? 0 : exp_done), "R7 rd_valid clock", rdv_c, w ? 0 : exp_done);
    chk(rdy_done, "R10 ready in done cycle", int'(rdy_done), 1);
    chk(!bad_nop, "R9 NOP while deselected", int'(bad_nop), 0);
    if (noise) chk(1, "R11 noise access", 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog R10 actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && ras_n && cas_n && we_n && !rd_valid && !done && req_ready, "R1 in reset",
        {cs_n, ras_n, cas_n, we_n, rd_valid, done, req_ready}, 7'b1111001);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(cs_n && ras_n && cas_n && we_n && !rd_valid && !done && req_ready, "R1 after reset",
        {cs_n, ras_n, cas_n, we_n, rd_valid, done, req_ready}, 7'b1111001);
    // back-to-back: each request presented in the previous done cycle (R10)
    for (int i = 0; i < NV; i++) begin
      logic [11:0] v;
      v = VEC[i];
      run_acc(v[11], v[10:9], v[8], v[7], v[6], v[5], int'(v[4:0]), 0,
              2'(i), 12'h400 + 12'(i * 37), 9'h100 + 9'(i * 5));
    end
    req_valid = 0;
    repeat (4) @(negedge clk);
    // conflicting request and inverted config during a busy access (R11, R12)
    run_acc(1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 10, 1, 2'd3, 12'hABC, 9'h0F3);
    req_valid = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(cs_n && ras_n && cas_n && we_n && !done, "R12 no command after ignored request",
          {cs_n, ras_n, cas_n, we_n, done}, 5'b11110);
    end
    // write with fast leadoff off: still clock 3 (R8)
    run_acc(1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 7, 0, 2'd1, 12'h055, 9'h1AA);
    req_valid = 0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule